// File: doc/BRIEF.md
# Per-Channel DMA Register Window Bridge

This block gives each of eight DMA channels its own 16-byte I/O window that software can move to any 16-bit base. A CPU access that falls inside an enabled window is handled in one of two ways. The channel's address, count and page bytes are held locally and can be read or written directly. Accesses to the controller-wide functions (command, status, request, mask and mode) are turned into register cycles on a legacy port, which leads to a pair of classic cascaded DMA controllers.

Channels 0-3 belong to the first controller, whose registers start at legacy address 0x00. Channels 4-7 belong to the second, whose registers start at 0xC0. Page bytes are forwarded to a separate page-register range, and the bridge translates the channel number to a page slot on the way. Two offsets do more than a plain copy. One expands into a four-write sequence that masks every channel of the owning controller. The other builds a single-mask command from the written data and the channel number.

The CPU side is a strobe-and-done slave port. A strobe is accepted only while `io_ready` is high. Every access that hits a window ends with a one-cycle `io_done`, and for reads `io_rdata` is valid in that same cycle. Forwarded cycles use a request/acknowledge handshake. The CPU is held off (`io_ready` low) until every forwarded write of an access has been acknowledged.

Top module: `dma_chan_window_bridge`

## Requirements
- R1: A window answers only when its enable is set and its 16-bit base is nonzero. It then decodes every address whose bits 15:4 equal base bits 15:4. An access that hits no window gets no `io_done`, has no effect and causes no legacy cycle.
- R2: When enabled windows overlap, the lowest-numbered channel owns the access.
- R3: A write to offset 0 replaces the low byte of the channel's 16-bit base address. A write to offset 1 replaces its high byte. Either write also loads the current address from the new base. Reads of offsets 0 and 1 return the low and high bytes of the current address.
- R4: Offsets 4 and 5 behave the same way for the base count and the current count.
- R5: A write to offset 2 stores the channel's page byte, which offset 2 reads back. The write is also forwarded as a legacy write to page base + slot. The page base is 0x80 for channels 0-3 and 0x88 for channels 4-7. The slot is picked by channel bits 1:0 with the map 0→7, 1→3, 2→1, 3→2.
- R6: Writes to offsets 8, 9, A, B and D are forwarded unchanged to controller base + offset. The controller base is 0x00 for channels 0-3 and 0xC0 for channels 4-7.
- R7: A read of offset 9 is forwarded as a legacy read of controller base + 8. The value returned on `lg_rdata` is then given back on `io_rdata`.
- R8: A write to offset E issues four legacy writes to controller base + A, carrying the data 0, 1, 2 and 3 in that order. `io_ready` stays low until the last of them is acknowledged.
- R9: A write to offset F issues one legacy write to controller base + A. Its data is (wdata << 2) | channel[1:0], truncated to 8 bits.
- R10: Reads of offsets 3, 6, 7, 8, A-F return 0xFF. Writes to offsets 3, 6, 7 and C complete with no legacy cycle and leave every register unchanged.
- R11: `lg_req` stays high, with `lg_addr`, `lg_we` and `lg_wdata` stable, until `lg_ack`. Each acknowledged cycle is one transfer.
- R12: A configuration write (base or enable) is used from the next clock cycle on. From that cycle the old window no longer responds.
- R13: After reset, all windows are disabled, all channel registers are zero, `io_ready` is high, `lg_req` and `io_done` are low and `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load window base/enable for `cfg_ch` |
| cfg_ch | input | 3 | Channel being configured |
| cfg_base | input | 16 | New window base |
| cfg_en | input | 1 | New window enable |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | CPU write strobe |
| io_rd | input | 1 | CPU read strobe |
| io_ready | output | 1 | Bridge can accept a strobe |
| io_done | output | 1 | One-cycle completion of a hit access |
| io_rdata | output | 8 | Read data, valid with `io_done` |
| lg_req | output | 1 | Legacy cycle request |
| lg_we | output | 1 | Legacy cycle is a write |
| lg_addr | output | 8 | Legacy register address |
| lg_wdata | output | 8 | Legacy write data |
| lg_ack | input | 1 | Legacy cycle acknowledge |
| lg_rdata | input | 8 | Legacy read data, sampled with `lg_ack` |

## Verification
The assertions take three things for granted. The legacy target raises `lg_ack` only while `lg_req` is high. The CPU raises at most one of `io_wr` and `io_rd` in a cycle. The CPU holds every strobe to a single cycle taken while `io_ready` is high. The bench's target acknowledges one cycle after each request and then drops `lg_ack` for a cycle, so acknowledges never arrive without a request. The bench's CPU tasks wait for `io_ready`, pulse exactly one strobe for one cycle and then wait for `io_done`, so no access overlaps a running forward sequence.

// File: rtl/dcw_pkg.sv
// Shared constants and helpers for the DMA channel window bridge.
// Assumes byte-wide data and an 8-bit legacy register address space.
package dcw_pkg;
    localparam int DATA_W   = 8;
    localparam int LG_AW    = 8;
    localparam int SEQ_CW   = 3;  // width of a forward-burst length

    localparam logic [LG_AW-1:0] CTRL_LO_BASE = 8'h00;
    localparam logic [LG_AW-1:0] CTRL_HI_BASE = 8'hC0;
    localparam logic [LG_AW-1:0] PAGE_LO_BASE = 8'h80;
    localparam logic [LG_AW-1:0] PAGE_HI_BASE = 8'h88;

    // Window offsets with a decoded meaning
    localparam logic [3:0] OFF_ADDR_LO = 4'h0;
    localparam logic [3:0] OFF_ADDR_HI = 4'h1;
    localparam logic [3:0] OFF_PAGE    = 4'h2;
    localparam logic [3:0] OFF_CNT_LO  = 4'h4;
    localparam logic [3:0] OFF_CNT_HI  = 4'h5;
    localparam logic [3:0] OFF_STATUS  = 4'h8;
    localparam logic [3:0] OFF_STS_ALT = 4'h9;
    localparam logic [3:0] OFF_SMASK   = 4'hA;
    localparam logic [3:0] OFF_MODE    = 4'hB;
    localparam logic [3:0] OFF_CLEAR   = 4'hD;
    localparam logic [3:0] OFF_MASKALL = 4'hE;
    localparam logic [3:0] OFF_MASKCH  = 4'hF;

    // One forwarded legacy cycle (or a burst of them)
    typedef struct packed {
        logic              we;
        logic [LG_AW-1:0]  addr;
        logic [DATA_W-1:0] data;
        logic [SEQ_CW-1:0] cnt;
    } fwd_op_t;

    // Page-register slot for a channel within its controller
    function automatic logic [2:0] page_slot(input logic [1:0] sub);
        case (sub)
            2'd0:    page_slot = 3'd7;
            2'd1:    page_slot = 3'd3;
            2'd2:    page_slot = 3'd1;
            default: page_slot = 3'd2;
        endcase
    endfunction
endpackage

// File: rtl/dcw_chan_bank.sv
// Per-channel state: window configuration plus the locally held
// base/current address, base/current count and page byte.
// Assumes at most one local write per cycle, already decoded by the top.
module dcw_chan_bank #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int REG_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_en,
    input  logic              loc_we,
    input  logic [CH_W-1:0]   loc_ch,
    input  logic [3:0]        loc_off,
    input  logic [DATA_W-1:0] loc_data,
    output logic [ADDR_W-1:0] win_base [NUM_CH],
    output logic              win_en   [NUM_CH],
    output logic [REG_W-1:0]  cur_addr [NUM_CH],
    output logic [REG_W-1:0]  cur_cnt  [NUM_CH],
    output logic [DATA_W-1:0] page     [NUM_CH]
);
    import dcw_pkg::*;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [ADDR_W-1:0] base_q;
        logic              en_q;
        logic [REG_W-1:0]  badr_q, cadr_q, bcnt_q, ccnt_q;
        logic [DATA_W-1:0] page_q;
        logic              sel;

        assign sel = loc_we && (loc_ch == CH_W'(g));

        // Window relocation: registered so it applies from the next cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                en_q   <= 1'b0;
            end else if (cfg_we && (cfg_ch == CH_W'(g))) begin
                base_q <= cfg_base;
                en_q   <= cfg_en;
            end
        end

        // Byte writes to base registers, current copies reloaded alongside
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                badr_q <= '0;
                cadr_q <= '0;
                bcnt_q <= '0;
                ccnt_q <= '0;
                page_q <= '0;
            end else if (sel) begin
                case (loc_off)
                    OFF_ADDR_LO: begin
                        badr_q <= {badr_q[REG_W-1:DATA_W], loc_data};
                        cadr_q <= {badr_q[REG_W-1:DATA_W], loc_data};
                    end
                    OFF_ADDR_HI: begin
                        badr_q <= {loc_data, badr_q[DATA_W-1:0]};
                        cadr_q <= {loc_data, badr_q[DATA_W-1:0]};
                    end
                    OFF_CNT_LO: begin
                        bcnt_q <= {bcnt_q[REG_W-1:DATA_W], loc_data};
                        ccnt_q <= {bcnt_q[REG_W-1:DATA_W], loc_data};
                    end
                    OFF_CNT_HI: begin
                        bcnt_q <= {loc_data, bcnt_q[DATA_W-1:0]};
                        ccnt_q <= {loc_data, bcnt_q[DATA_W-1:0]};
                    end
                    OFF_PAGE: page_q <= loc_data;
                    default: ;
                endcase
            end
        end

        assign win_base[g] = base_q;
        assign win_en[g]   = en_q;
        assign cur_addr[g] = cadr_q;
        assign cur_cnt[g]  = ccnt_q;
        assign page[g]     = page_q;
    end
endmodule

// File: rtl/dcw_decode.sv
// Window hit detection. A window matches on address bits above the
// 16-byte offset when enabled with a nonzero base; lowest channel wins.
module dcw_decode #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [ADDR_W-1:0] win_base [NUM_CH],
    input  logic              win_en   [NUM_CH],
    output logic              hit,
    output logic [CH_W-1:0]   hit_ch
);
    // Priority scan from the top down so the lowest match is kept last
    always_comb begin
        hit    = 1'b0;
        hit_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (win_en[i] && (win_base[i] != '0) &&
                (io_addr[ADDR_W-1:4] == win_base[i][ADDR_W-1:4])) begin
                hit    = 1'b1;
                hit_ch = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/dcw_fwd_seq.sv
// Legacy-port sequencer: issues a burst of one or more request/acknowledge
// cycles, incrementing the write data between cycles of a burst.
// Assumes start is raised only while idle and ack only while req is high.
module dcw_fwd_seq #(
    parameter int LG_AW  = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_we,
    input  logic [LG_AW-1:0]  op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [CNT_W-1:0]  op_cnt,
    input  logic              lg_ack,
    output logic              lg_req,
    output logic              lg_we,
    output logic [LG_AW-1:0]  lg_addr,
    output logic [DATA_W-1:0] lg_wdata,
    output logic              busy,
    output logic              fin
);
    logic [CNT_W-1:0] left_q;

    // Burst control: load on start, step or finish on each acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_req   <= 1'b0;
            lg_we    <= 1'b0;
            lg_addr  <= '0;
            lg_wdata <= '0;
            left_q   <= '0;
        end else if (start && !lg_req) begin
            lg_req   <= 1'b1;
            lg_we    <= op_we;
            lg_addr  <= op_addr;
            lg_wdata <= op_data;
            left_q   <= op_cnt - CNT_W'(1);
        end else if (lg_req && lg_ack) begin
            if (left_q == '0) begin
                lg_req <= 1'b0;
            end else begin
                left_q   <= left_q - CNT_W'(1);
                lg_wdata <= lg_wdata + DATA_W'(1);
            end
        end
    end

    assign busy = lg_req;
    assign fin  = lg_req && lg_ack && (left_q == '0);
endmodule

// File: rtl/dma_chan_window_bridge.sv
// Top of the per-channel DMA register window bridge. Decodes CPU I/O
// strobes against eight relocatable windows, serves channel registers
// locally and forwards controller-wide accesses to the legacy port.
// Assumes single-cycle strobes, issued only while io_ready is high.
module dma_chan_window_bridge #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 16,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int DW    = dcw_pkg::DATA_W,
    localparam int LAW   = dcw_pkg::LG_AW,
    localparam int RW    = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DW-1:0]     io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              io_ready,
    output logic              io_done,
    output logic [DW-1:0]     io_rdata,
    output logic              lg_req,
    output logic              lg_we,
    output logic [LAW-1:0]    lg_addr,
    output logic [LAW-1:0]    lg_wdata,
    input  logic              lg_ack,
    input  logic [DW-1:0]     lg_rdata
);
    import dcw_pkg::*;

    logic [ADDR_W-1:0] win_base [NUM_CH];
    logic              win_en   [NUM_CH];
    logic [RW-1:0]     cur_addr [NUM_CH];
    logic [RW-1:0]     cur_cnt  [NUM_CH];
    logic [DW-1:0]     page     [NUM_CH];

    logic            hit, acc, busy, fin, loc_we;
    logic [CH_W-1:0] hit_ch;
    logic [3:0]      off;
    logic [LAW-1:0]  ctrl_base, page_base;
    logic [DW-1:0]   loc_rd;
    logic            fwd_start;
    fwd_op_t         op;

    assign off      = io_addr[3:0];
    assign io_ready = !busy;
    assign acc      = (io_wr || io_rd) && io_ready && hit;

    dcw_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .io_addr (io_addr),
        .win_base(win_base),
        .win_en  (win_en),
        .hit     (hit),
        .hit_ch  (hit_ch)
    );

    // Channel-local writes: address, count and page bytes
    always_comb begin
        loc_we = acc && io_wr &&
                 ((off == OFF_ADDR_LO) || (off == OFF_ADDR_HI) ||
                  (off == OFF_CNT_LO)  || (off == OFF_CNT_HI)  ||
                  (off == OFF_PAGE));
    end

    dcw_chan_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_ch  (cfg_ch),
        .cfg_base(cfg_base),
        .cfg_en  (cfg_en),
        .loc_we  (loc_we),
        .loc_ch  (hit_ch),
        .loc_off (off),
        .loc_data(io_wdata),
        .win_base(win_base),
        .win_en  (win_en),
        .cur_addr(cur_addr),
        .cur_cnt (cur_cnt),
        .page    (page)
    );

    // Controller and page base chosen by the channel's upper half
    assign ctrl_base = hit_ch[CH_W-1] ? CTRL_HI_BASE : CTRL_LO_BASE;
    assign page_base = hit_ch[CH_W-1] ? PAGE_HI_BASE : PAGE_LO_BASE;

    // Forwarding decode: which legacy burst an accepted access becomes
    always_comb begin
        fwd_start = 1'b0;
        op.we     = 1'b1;
        op.addr   = ctrl_base + LAW'(off);
        op.data   = io_wdata;
        op.cnt    = SEQ_CW'(1);
        if (acc && io_wr) begin
            case (off)
                OFF_PAGE: begin
                    fwd_start = 1'b1;
                    op.addr   = page_base + LAW'(page_slot(hit_ch[1:0]));
                end
                OFF_STATUS, OFF_STS_ALT, OFF_SMASK, OFF_MODE, OFF_CLEAR:
                    fwd_start = 1'b1;
                OFF_MASKALL: begin
                    fwd_start = 1'b1;
                    op.addr   = ctrl_base + LAW'(OFF_SMASK);
                    op.data   = '0;
                    op.cnt    = SEQ_CW'(4);
                end
                OFF_MASKCH: begin
                    fwd_start = 1'b1;
                    op.addr   = ctrl_base + LAW'(OFF_SMASK);
                    op.data   = {io_wdata[DW-3:0], hit_ch[1:0]};
                end
                default: ;
            endcase
        end else if (acc && io_rd && (off == OFF_STS_ALT)) begin
            fwd_start = 1'b1;
            op.we     = 1'b0;
            op.addr   = ctrl_base + LAW'(OFF_STATUS);
        end
    end

    dcw_fwd_seq #(.LG_AW(LAW), .DATA_W(DW), .CNT_W(SEQ_CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fwd_start),
        .op_we   (op.we),
        .op_addr (op.addr),
        .op_data (op.data),
        .op_cnt  (op.cnt),
        .lg_ack  (lg_ack),
        .lg_req  (lg_req),
        .lg_we   (lg_we),
        .lg_addr (lg_addr),
        .lg_wdata(lg_wdata),
        .busy    (busy),
        .fin     (fin)
    );

    // Local read mux for the hit channel
    always_comb begin
        case (off)
            OFF_ADDR_LO: loc_rd = cur_addr[hit_ch][DW-1:0];
            OFF_ADDR_HI: loc_rd = cur_addr[hit_ch][RW-1:DW];
            OFF_PAGE:    loc_rd = page[hit_ch];
            OFF_CNT_LO:  loc_rd = cur_cnt[hit_ch][DW-1:0];
            OFF_CNT_HI:  loc_rd = cur_cnt[hit_ch][RW-1:DW];
            default:     loc_rd = '1;
        endcase
    end

    // Completion pulse and read data for local and forwarded accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_done  <= 1'b0;
            io_rdata <= '1;
        end else begin
            io_done <= (acc && !fwd_start) || fin;
            if (acc && !fwd_start) begin
                io_rdata <= loc_rd;
            end else if (fin) begin
                io_rdata <= lg_rdata;
            end
        end
    end
endmodule

// File: rtl/dcw_bridge_chk.sv
// Protocol checker for the window bridge, bound to the top module.
// Assumes the legacy target acknowledges only while a request is open.
module dcw_bridge_chk #(
    parameter int LAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           io_ready,
    input logic           lg_req,
    input logic           lg_ack,
    input logic           lg_we,
    input logic [LAW-1:0] lg_addr,
    input logic [LAW-1:0] lg_wdata
);
    // R11: an unacknowledged request holds its address, direction and data
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_req && !lg_ack) |=>
            (lg_req && $stable(lg_addr) && $stable(lg_we) && $stable(lg_wdata)));

    // R8: the CPU side is held off while any forwarded cycle is open
    a_r8_busy_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        lg_req |-> !io_ready);

    // R7: the only forwarded read is a status read
    a_r7_read_is_status: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_req && !lg_we) |-> (lg_addr[3:0] == 4'h8));

    // R5: page-register addresses are only ever written
    a_r5_page_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_req && (lg_addr[7:4] == 4'h8)) |-> lg_we);
endmodule

bind dma_chan_window_bridge dcw_bridge_chk u_chk (.*);

// File: tb/dma_chan_window_bridge_tb.sv
// Bench for the DMA channel window bridge: vector table, then directed tests.
module dma_chan_window_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_en = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic        io_ready, io_done;
    logic [7:0]  io_rdata;
    logic        lg_req, lg_we, lg_ack;
    logic [7:0]  lg_addr, lg_wdata, lg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] log_a [64];
    logic [7:0] log_d [64];
    int log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_window_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_base(cfg_base), .cfg_en(cfg_en),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_ready(io_ready), .io_done(io_done), .io_rdata(io_rdata),
        .lg_req(lg_req), .lg_we(lg_we), .lg_addr(lg_addr), .lg_wdata(lg_wdata),
        .lg_ack(lg_ack), .lg_rdata(lg_rdata)
    );

    // Legacy target: ack one cycle after request, status value = addr ^ A5
    always_ff @(posedge clk) begin
        if (!rst_n) lg_ack <= 1'b0;
        else        lg_ack <= lg_req && !lg_ack;
    end
    assign lg_rdata = lg_addr ^ 8'hA5;

    // Record every acknowledged legacy write
    always @(posedge clk) begin
        if (rst_n && lg_req && lg_ack && lg_we && log_n < 64) begin
            log_a[log_n] <= lg_addr;
            log_d[log_n] <= lg_wdata;
            log_n <= log_n + 1;
        end
    end

    // Stimulus table: {is_write, req_no[3:0], addr[15:0], data[7:0], expect[7:0]}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b1, 4'd3,  16'h0100, 8'h12, 8'h00},   // R3 addr low
        {1'b1, 4'd3,  16'h0101, 8'h34, 8'h00},   // R3 addr high
        {1'b0, 4'd3,  16'h0100, 8'h00, 8'h12},
        {1'b0, 4'd3,  16'h0101, 8'h00, 8'h34},
        {1'b1, 4'd4,  16'h0104, 8'h56, 8'h00},   // R4 count low
        {1'b1, 4'd4,  16'h0105, 8'h78, 8'h00},   // R4 count high
        {1'b0, 4'd4,  16'h0104, 8'h00, 8'h56},
        {1'b0, 4'd4,  16'h0105, 8'h00, 8'h78},
        {1'b1, 4'd5,  16'h0102, 8'h9A, 8'h00},   // R5 page store
        {1'b0, 4'd5,  16'h0102, 8'h00, 8'h9A},
        {1'b0, 4'd10, 16'h0103, 8'h00, 8'hFF},   // R10 undecoded read
        {1'b0, 4'd10, 16'h010C, 8'h00, 8'hFF},
        {1'b0, 4'd7,  16'h0109, 8'h00, 8'hAD},   // R7 status, first ctrl
        {1'b0, 4'd7,  16'h0259, 8'h00, 8'h6D},   // R7 status, second ctrl
        {1'b1, 4'd3,  16'h0250, 8'hAB, 8'h00},   // R3 other channel
        {1'b0, 4'd3,  16'h0250, 8'h00, 8'hAB},
        {1'b0, 4'd3,  16'h0100, 8'h00, 8'h12}    // R3 channel 1 kept
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_cfg(input logic [2:0] ch, input logic [15:0] base, input logic en);
        cfg_we = 1'b1; cfg_ch = ch; cfg_base = base; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One CPU access; returns whether io_done came and the read data
    task automatic io_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                             output bit got, output logic [7:0] rd);
        while (!io_ready) @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        got = 1'b0; rd = 8'h00;
        for (int i = 0; i < 40 && !got; i++) begin
            if (io_done) begin got = 1'b1; rd = io_rdata; end
            else @(negedge clk);
        end
    endtask

    task automatic wr_chk(input string tag, input logic [15:0] a, input logic [7:0] d);
        bit g; logic [7:0] r;
        io_access(1'b1, a, d, g, r);
        check({tag, " write done"}, 8'(g), 8'd1);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        bit g; logic [7:0] r;
        io_access(1'b0, a, 8'h00, g, r);
        check({tag, " read done"}, 8'(g), 8'd1);
        check({tag, " read data"}, r, exp);
    endtask

    task automatic miss_chk(input string tag, input logic [15:0] a);
        bit g; logic [7:0] r;
        int n0 = log_n;
        io_access(1'b0, a, 8'h00, g, r);
        check({tag, " no response"}, 8'(g), 8'd0);
        check({tag, " no legacy cycle"}, 8'(log_n - n0), 8'd0);
    endtask

    task automatic fwd1_chk(input string tag, input logic [15:0] a, input logic [7:0] d,
                            input logic [7:0] ea, input logic [7:0] ed);
        int n0 = log_n;
        wr_chk(tag, a, d);
        check({tag, " one legacy write"}, 8'(log_n - n0), 8'd1);
        check({tag, " legacy addr"}, log_a[n0], ea);
        check({tag, " legacy data"}, log_d[n0], ed);
    endtask

    // Watchdog: a hung run is a failure that still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit g; logic [7:0] r;
        int n0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 io_ready", 8'(io_ready), 8'd1);
        check("R13 lg_req", 8'(lg_req), 8'd0);
        check("R13 io_done", 8'(io_done), 8'd0);
        check("R13 io_rdata", io_rdata, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        miss_chk("R13 windows off after reset", 16'h0100);

        do_cfg(3'd1, 16'h0100, 1'b1);
        do_cfg(3'd5, 16'h0250, 1'b1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][35:32], i);
            if (VEC[i][36]) wr_chk(tag, VEC[i][31:16], VEC[i][15:8]);
            else            rd_chk(tag, VEC[i][31:16], VEC[i][7:0]);
        end

        // R5 page forwarding and slot map
        fwd1_chk("R5 ch1 page", 16'h0102, 8'h9A, 8'h83, 8'h9A);
        fwd1_chk("R5 ch5 page", 16'h0252, 8'h3C, 8'h8B, 8'h3C);
        do_cfg(3'd0, 16'h0600, 1'b1);
        fwd1_chk("R5 ch0 page", 16'h0602, 8'h21, 8'h87, 8'h21);

        // R6 plain forwards
        fwd1_chk("R6 ch1 off8", 16'h0108, 8'h44, 8'h08, 8'h44);
        fwd1_chk("R6 ch5 offD", 16'h025D, 8'h55, 8'hCD, 8'h55);
        fwd1_chk("R6 ch1 offB", 16'h010B, 8'h66, 8'h0B, 8'h66);

        // R8 mask-all sequence, CPU held off meanwhile
        n0 = log_n;
        io_addr = 16'h010E; io_wdata = 8'h77; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R8 ready low during sequence", 8'(io_ready), 8'd0);
        g = 1'b0;
        for (int i = 0; i < 40 && !g; i++) begin
            if (io_done) g = 1'b1; else @(negedge clk);
        end
        check("R8 sequence done", 8'(g), 8'd1);
        check("R11 four transfers", 8'(log_n - n0), 8'd4);
        for (int k = 0; k < 4; k++) begin
            check("R8 mask addr", log_a[n0+k], 8'h0A);
            check("R8 mask data", log_d[n0+k], 8'(k));
        end
        n0 = log_n;
        wr_chk("R8 ch5", 16'h025E, 8'h00);
        check("R8 ch5 count", 8'(log_n - n0), 8'd4);
        check("R8 ch5 addr", log_a[n0+3], 8'hCA);
        check("R8 ch5 last data", log_d[n0+3], 8'h03);

        // R9 single-mask build
        fwd1_chk("R9 ch5", 16'h025F, 8'h03, 8'hCA, 8'h0D);
        fwd1_chk("R9 ch1", 16'h010F, 8'h02, 8'h0A, 8'h09);

        // R10 ignored writes
        n0 = log_n;
        wr_chk("R10 off3", 16'h0103, 8'hEE);
        wr_chk("R10 offC", 16'h010C, 8'hEE);
        wr_chk("R10 off7", 16'h0107, 8'hEE);
        check("R10 no legacy cycle", 8'(log_n - n0), 8'd0);
        rd_chk("R10 addr unchanged", 16'h0100, 8'h12);
        rd_chk("R10 count unchanged", 16'h0104, 8'h56);
        rd_chk("R10 page unchanged", 16'h0102, 8'h9A);

        // R1 disabled window and zero base
        do_cfg(3'd2, 16'h0300, 1'b0);
        miss_chk("R1 disabled window", 16'h0300);
        do_cfg(3'd2, 16'h0000, 1'b1);
        miss_chk("R1 zero base", 16'h0005);

        // R12 relocation effective next cycle
        do_cfg(3'd1, 16'h0400, 1'b1);
        rd_chk("R12 new window", 16'h0400, 8'h12);
        miss_chk("R12 old window gone", 16'h0100);

        // R2 overlap priority
        do_cfg(3'd3, 16'h0500, 1'b1);
        do_cfg(3'd6, 16'h0500, 1'b1);
        wr_chk("R2 write to overlap", 16'h0500, 8'h11);
        do_cfg(3'd3, 16'h0500, 1'b0);
        rd_chk("R2 higher channel untouched", 16'h0500, 8'h00);
        fwd1_chk("R2 ch6 page", 16'h0502, 8'h5E, 8'h89, 8'h5E);
        do_cfg(3'd3, 16'h0500, 1'b1);
        rd_chk("R2 lowest channel wins", 16'h0500, 8'h11);
        rd_chk("R2 lowest channel page", 16'h0502, 8'h00);

        io_access(1'b0, 16'h0409, 8'h00, g, r);
        check("R7 relocated status", r, 8'hAD);

        finish_run();
    end
endmodule